// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block sends a stereo pair of parallel samples as one serial bit stream. It works as a slave: an external bit clock and an external word or frame clock both arrive as level inputs and are oversampled by the system clock. The block drives one data output, and that output advances on a chosen edge of the bit clock.

Five framing conventions are available: left-justified, I2S, right-justified, and two frame-sync modes. In the frame-sync modes a short pulse starts the frame, and the left and right words follow each other with no gap. The word length can be 16, 20, 24 or 32 bits. Words go out MSB first, and the output drives zero whenever no word bit is due.

A new pair is taken once per frame through a ready/valid handshake. If no pair is offered, the last pair is sent again and a one-cycle underrun pulse is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: With `launchRise` = 0 the output advances only on falling bit-clock edges. With `launchRise` = 1 it advances only on rising edges.
- R2: `wordLenSel` encodes the word length as 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. A sample occupies bits W-1..0 of its input, and any bits above are ignored. Bits go out MSB first.
- R3: `fmtSel` = 0 (left-justified). Word clock high carries the left channel. The MSB goes out in the first bit period after each word-clock change, and zeros follow the LSB until the next change.
- R4: `fmtSel` = 1 (I2S). Word clock low carries the left channel. The MSB goes out one bit period after each word-clock change.
- R5: `fmtSel` = 2 (right-justified). Word clock high carries the left channel. The block uses the length of the previous half period, so the LSB lands in the last bit period before the next change and earlier periods carry zero. The first half period after reset carries zeros.
- R6: In right-justified mode with 32-bit words, the output stays zero.
- R7: `fmtSel` = 3 (late frame-sync). The left MSB goes out in the bit period that starts with the sync rise. The right word follows the left LSB directly, and the output is zero for the rest of the frame.
- R8: `fmtSel` = 4 (early frame-sync). This works as in R7, but everything is delayed by one bit period.
- R9: `pairReady` is high for one system cycle at each frame start. A frame starts at the word-clock rise for left-justified, right-justified and the frame-sync modes, and at the fall for I2S. A pair is taken when `pairValid` is high in that cycle.
- R10: If `pairValid` is low at a frame start, the previous pair is sent again and `underrun` is high for exactly one cycle.
- R11: During reset, `serOut`, `pairReady` and `underrun` are low. Until the first pair is taken, the held pair is zero.
- R12: `serOut` changes only in the system cycle after a launch edge is sampled. The sample edge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtSel | input | 3 | Framing convention |
| wordLenSel | input | 2 | Word length code |
| launchRise | input | 1 | 1 launches data on rising bit-clock edges |
| bclkIn | input | 1 | External bit clock |
| lrckIn | input | 1 | External word clock or frame sync |
| leftData | input | SAMPLE_W | Left sample, right-aligned |
| rightData | input | SAMPLE_W | Right sample, right-aligned |
| pairValid | input | 1 | Sample pair offered |
| pairReady | output | 1 | Pair accepted this cycle (frame start) |
| serOut | output | 1 | Serial data output |
| underrun | output | 1 | One-cycle pulse when a frame starts without a pair |

## Verification
The bench builds the block with its defaults: a 32-bit sample width and an 8-bit bit-period counter. The wide sample width makes the 32-bit word in every mode reachable, including the right-justified case that must stay silent. The counter width allows half periods and frames of up to 255 bit clocks, so the bench can run frames from exactly two words long up to 64 bit clocks. Both launch polarities are exercised, along with the half-period-equals-word-length case of the end-aligned mode.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [2:0] {
    FMT_LEFT      = 3'd0,
    FMT_I2S       = 3'd1,
    FMT_RIGHT     = 3'd2,
    FMT_DSP_LATE  = 3'd3,
    FMT_DSP_EARLY = 3'd4
  } fmtE;

  // strobes from the control towards the datapath
  typedef struct packed {
    logic launch;      // launch edge of the bit clock seen this cycle
    logic load;        // start a new word at this launch
    logic loadRight;   // the new word is the right channel
    logic frameStart;  // frame boundary: pair handshake point
  } txStrobeT;

  function automatic logic [5:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] fmtSel,
  input  logic [1:0] wordLenSel,
  input  logic       launchRise,
  input  logic       bclkIn,
  input  logic       lrckIn,
  output txStrobeT   strb
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fmtE              fmt;
  logic             primed, bclkQ, lrckQ, synced, seenEdge, halfOk;
  logic [CNT_W-1:0] bitCnt, halfLen;
  logic             launch, anyEdge, refEdge, isDsp, active;
  logic [CNT_W-1:0] bitInc, kNow, wLen, offK, halfLenNow, rjStart;
  logic             halfOkNow, rjOk, hit, right;

  assign fmt    = fmtE'(fmtSel);
  assign isDsp  = (fmt == FMT_DSP_LATE) || (fmt == FMT_DSP_EARLY);
  assign launch = primed && (bclkIn != bclkQ) && (bclkIn == launchRise);

  // word-clock change seen at a launch edge; frame-sync modes count from the rise only
  assign anyEdge = launch && synced && (lrckIn != lrckQ);
  assign refEdge = isDsp ? (anyEdge && lrckIn) : anyEdge;

  assign bitInc = (bitCnt == CNT_MAX) ? bitCnt : bitCnt + 1'b1;
  assign kNow   = refEdge ? '0 : bitInc;
  assign active = seenEdge || refEdge;

  assign wLen = CNT_W'(wordBits(wordLenSel));
  assign offK = ((fmt == FMT_I2S) || (fmt == FMT_DSP_EARLY)) ? CNT_W'(1) : '0;

  // end alignment uses the length of the half period just finished
  assign halfLenNow = refEdge ? bitInc : halfLen;
  assign halfOkNow  = refEdge ? seenEdge : halfOk;
  assign rjOk       = halfOkNow && (wordLenSel != 2'd3) && (halfLenNow >= wLen);
  assign rjStart    = halfLenNow - wLen;

  always_comb begin
    hit   = 1'b0;
    right = 1'b0;
    case (fmt)
      FMT_I2S: begin
        hit   = (kNow == CNT_W'(1));
        right = lrckIn;
      end
      FMT_RIGHT: begin
        hit   = rjOk && (kNow == rjStart);
        right = !lrckIn;
      end
      FMT_DSP_LATE, FMT_DSP_EARLY: begin
        if (kNow == offK) begin
          hit = 1'b1;
        end else if (kNow == offK + wLen) begin
          hit   = 1'b1;
          right = 1'b1;
        end
      end
      default: begin
        hit   = (kNow == '0);
        right = !lrckIn;
      end
    endcase
  end

  always_comb begin
    strb.launch     = launch;
    strb.load       = launch && active && hit;
    strb.loadRight  = right;
    strb.frameStart = refEdge && ((fmt == FMT_I2S) ? !lrckIn : lrckIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      bclkQ    <= 1'b0;
      lrckQ    <= 1'b0;
      synced   <= 1'b0;
      seenEdge <= 1'b0;
      halfOk   <= 1'b0;
      bitCnt   <= '0;
      halfLen  <= '0;
    end else begin
      primed <= 1'b1;
      bclkQ  <= bclkIn;
      if (launch) begin
        synced <= 1'b1;
        lrckQ  <= lrckIn;
        if (refEdge) begin
          bitCnt   <= '0;
          seenEdge <= 1'b1;
          halfLen  <= bitInc;
          halfOk   <= seenEdge;
        end else begin
          bitCnt <= bitInc;
        end
      end
    end
  end

endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobeT            strb,
  input  logic [1:0]          wordLenSel,
  input  logic [SAMPLE_W-1:0] leftData,
  input  logic [SAMPLE_W-1:0] rightData,
  input  logic                pairValid,
  output logic                serOut,
  output logic                underrun
);

  localparam int SH_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] holdL, holdR, shReg;
  logic [SAMPLE_W-1:0] srcL, srcR, word, aligned;
  logic [SH_W-1:0]     shAmt;
  logic                take;

  assign take  = strb.frameStart && pairValid;
  // a pair taken this cycle may also be the word started this cycle
  assign srcL  = take ? leftData  : holdL;
  assign srcR  = take ? rightData : holdR;
  assign word  = strb.loadRight ? srcR : srcL;
  // push the W live bits to the top; zeros fill in behind them
  assign shAmt   = SH_W'(SAMPLE_W) - SH_W'(wordBits(wordLenSel));
  assign aligned = word << shAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdL    <= '0;
      holdR    <= '0;
      shReg    <= '0;
      serOut   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= strb.frameStart && !pairValid;
      if (take) begin
        holdL <= leftData;
        holdR <= rightData;
      end
      if (strb.launch) begin
        if (strb.load) begin
          serOut <= aligned[SAMPLE_W-1];
          shReg  <= aligned << 1;
        end else begin
          serOut <= shReg[SAMPLE_W-1];
          shReg  <= shReg << 1;
        end
      end
    end
  end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          fmtSel,
  input  logic [1:0]          wordLenSel,
  input  logic                launchRise,
  input  logic                bclkIn,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] leftData,
  input  logic [SAMPLE_W-1:0] rightData,
  input  logic                pairValid,
  output logic                pairReady,
  output logic                serOut,
  output logic                underrun
);

  txStrobeT strb;

  audio_tx_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fmtSel     (fmtSel),
    .wordLenSel (wordLenSel),
    .launchRise (launchRise),
    .bclkIn     (bclkIn),
    .lrckIn     (lrckIn),
    .strb       (strb)
  );

  audio_tx_datapath #(.SAMPLE_W(SAMPLE_W)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordLenSel (wordLenSel),
    .leftData   (leftData),
    .rightData  (rightData),
    .pairValid  (pairValid),
    .serOut     (serOut),
    .underrun   (underrun)
  );

  assign pairReady = strb.frameStart;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rstN,
  input logic launchRise,
  input logic bclkIn,
  input logic pairValid,
  input logic pairReady,
  input logic serOut,
  input logic underrun
);

  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    pairReady |=> !pairReady);

  a_r9_ready_at_launch: assert property (@(posedge clk) disable iff (!rstN)
    pairReady |-> (bclkIn == launchRise) && (bclkIn != $past(bclkIn)));

  a_r10_underrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(pairReady) && !$past(pairValid));

  a_r12_serout_timing: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> ($past(bclkIn) != $past(bclkIn, 2)));

  a_r1_serout_polarity: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> ($past(bclkIn) == $past(launchRise)));

endmodule

bind audio_ser_tx audio_ser_tx_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .launchRise (launchRise),
  .bclkIn     (bclkIn),
  .pairValid  (pairValid),
  .pairReady  (pairReady),
  .serOut     (serOut),
  .underrun   (underrun)
);

// File: tb/audio_ser_tx_test.sv
module audio_ser_tx_test;

  typedef struct packed {
    logic [2:0] fmt;
    logic [1:0] wsel;
    logic [7:0] half;
    logic       rise;
  } cfgT;

  localparam int NCFG = 13;
  // format, word-length code, bit clocks per half period (frame = 2*half), launch on rise
  localparam cfgT CFGS [NCFG] = '{
    '{3'd0, 2'd0, 8'd16, 1'b0},
    '{3'd0, 2'd2, 8'd28, 1'b1},
    '{3'd0, 2'd3, 8'd32, 1'b0},
    '{3'd1, 2'd0, 8'd18, 1'b0},
    '{3'd1, 2'd1, 8'd24, 1'b1},
    '{3'd2, 2'd0, 8'd20, 1'b0},
    '{3'd2, 2'd2, 8'd32, 1'b1},
    '{3'd2, 2'd1, 8'd20, 1'b0},
    '{3'd2, 2'd3, 8'd32, 1'b0},
    '{3'd3, 2'd0, 8'd16, 1'b0},
    '{3'd4, 2'd0, 8'd20, 1'b0},
    '{3'd3, 2'd3, 8'd32, 1'b1},
    '{3'd4, 2'd2, 8'd26, 1'b0}
  };

  logic        clk, rstN, launchRise, bclkIn, lrckIn, pairValid;
  logic [2:0]  fmtSel;
  logic [1:0]  wordLenSel;
  logic [31:0] leftData, rightData;
  logic        pairReady, serOut, underrun;

  int   checks, fails, tErr;
  logic launchLvl, lastOut;

  audio_ser_tx uut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .wordLenSel(wordLenSel),
    .launchRise(launchRise), .bclkIn(bclkIn), .lrckIn(lrckIn),
    .leftData(leftData), .rightData(rightData), .pairValid(pairValid),
    .pairReady(pairReady), .serOut(serOut), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) got=timeout exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int wOf(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int c, input int f, input int ch);
    return 32'(32'h9E3779B9 * (c * 8 + f * 2 + ch + 1)) ^ 32'h5AC317E4;
  endfunction

  function automatic string tagOf(input cfgT c);
    string t;
    case (c.fmt)
      3'd0: t = "R3";
      3'd1: t = "R4";
      3'd2: t = (c.wsel == 2'd3) ? "R6" : "R5";
      3'd3: t = "R7";
      default: t = "R8";
    endcase
    return c.rise ? {"R1 ", t, " R2"} : {t, " R2"};
  endfunction

  // expected frame, bit i = i-th bit period from the frame start
  function automatic logic [63:0] expFrame(input int fmt, input int w, input int half,
                                           input logic [31:0] l, input logic [31:0] r,
                                           input bit rjFirst);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < 2 * half; i++) begin
      int k, j;
      logic [31:0] wd;
      logic b;
      b = 1'b0;
      if (fmt >= 3) begin
        j = i - ((fmt == 4) ? 1 : 0);
        if (j >= 0 && j < w) b = l[w-1-j];
        else if (j >= w && j < 2 * w) b = r[2*w-1-j];
      end else begin
        k  = i % half;
        wd = (i < half) ? l : r;
        case (fmt)
          0: if (k < w) b = wd[w-1-k];
          1: if (k >= 1 && k <= w) b = wd[w-k];
          default: if (w != 32 && k >= half - w && !(rjFirst && i < half)) b = wd[half-1-k];
        endcase
      end
      e[i] = b;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one bit period: launch edge, two cycles, sample edge, two cycles
  task automatic driveBit(input logic lv, output logic got, output logic rdy, output logic und);
    @(negedge clk);
    bclkIn = launchLvl;
    lrckIn = lv;
    #1;
    rdy = pairReady;
    if (serOut !== lastOut) tErr++;
    @(negedge clk);
    und = underrun;
    @(negedge clk);
    got = serOut;
    bclkIn = !launchLvl;
    @(negedge clk);
    if (serOut !== got) tErr++;
    lastOut = got;
  endtask

  task automatic runFrame(input cfgT c, input logic [31:0] l, input logic [31:0] r,
                          input logic v, output logic [63:0] got, output logic rdy,
                          output logic und);
    logic leftLvl;
    leftLvl   = (c.fmt == 3'd1) ? 1'b0 : 1'b1;
    leftData  = l;
    rightData = r;
    pairValid = v;
    got = '0;
    rdy = 1'b0;
    und = 1'b0;
    for (int i = 0; i < 2 * int'(c.half); i++) begin
      logic lv, b, rr, uu;
      if (c.fmt >= 3'd3) lv = (i == 0);
      else lv = (i < int'(c.half)) ? leftLvl : !leftLvl;
      driveBit(lv, b, rr, uu);
      got[i] = b;
      if (i == 0) begin
        rdy = rr;
        und = uu;
      end
    end
  endtask

  task automatic doReset(input cfgT c);
    logic preLvl, b, rr, uu;
    preLvl = (c.fmt >= 3'd3) ? 1'b0 : ((c.fmt == 3'd1) ? 1'b1 : 1'b0);
    @(negedge clk);
    launchLvl  = c.rise;
    launchRise = c.rise;
    fmtSel     = c.fmt;
    wordLenSel = c.wsel;
    rstN       = 1'b0;
    bclkIn     = !c.rise;
    lrckIn     = preLvl;
    pairValid  = 1'b0;
    repeat (2) @(negedge clk);
    // R11: outputs quiet while reset is held
    check(serOut === 1'b0 && pairReady === 1'b0 && underrun === 1'b0, "R11 reset outputs",
          {61'd0, serOut, pairReady, underrun}, 64'd0);
    rstN    = 1'b1;
    lastOut = 1'b0;
    driveBit(preLvl, b, rr, uu);
  endtask

  initial begin
    logic [63:0] got, exp;
    logic        rdy, und;
    logic [31:0] l, r, la, ra;
    cfgT         cd;
    checks = 0; fails = 0; tErr = 0;
    rstN = 1'b0; bclkIn = 1'b1; lrckIn = 1'b0; launchRise = 1'b0; launchLvl = 1'b0;
    fmtSel = '0; wordLenSel = '0; leftData = '0; rightData = '0; pairValid = 1'b0;
    lastOut = 1'b0;

    // table walk: every format, several word lengths, both launch polarities (R1, R2)
    for (int c = 0; c < NCFG; c++) begin
      doReset(CFGS[c]);
      for (int f = 0; f < 3; f++) begin
        l = mk(c, f, 0);
        r = mk(c, f, 1);
        runFrame(CFGS[c], l, r, 1'b1, got, rdy, und);
        exp = expFrame(int'(CFGS[c].fmt), wOf(CFGS[c].wsel), int'(CFGS[c].half), l, r, f == 0);
        check(got === exp, tagOf(CFGS[c]), got, exp);
        check(rdy === 1'b1, "R9 ready at frame start", {63'd0, rdy}, 64'd1);
        check(und === 1'b0, "R10 no underrun with valid pair", {63'd0, und}, 64'd0);
      end
    end

    // R11 / R10: first frame without a pair sends the zero pair and flags underrun
    cd = CFGS[0];
    doReset(cd);
    runFrame(cd, mk(40, 0, 0), mk(40, 0, 1), 1'b0, got, rdy, und);
    check(got === 64'd0, "R11 held pair zero after reset", got, 64'd0);
    check(und === 1'b1, "R10 underrun pulse", {63'd0, und}, 64'd1);
    check(rdy === 1'b1, "R9 ready offered without valid", {63'd0, rdy}, 64'd1);

    // R10: a missing pair repeats the previous one
    la = mk(41, 0, 0);
    ra = mk(41, 0, 1);
    runFrame(cd, la, ra, 1'b1, got, rdy, und);
    exp = expFrame(0, 16, 16, la, ra, 1'b0);
    check(got === exp, "R3 frame before underrun", got, exp);
    runFrame(cd, mk(42, 0, 0), mk(42, 0, 1), 1'b0, got, rdy, und);
    check(got === exp, "R10 previous pair repeated", got, exp);
    check(und === 1'b1, "R10 underrun on repeat", {63'd0, und}, 64'd1);
    runFrame(cd, mk(43, 0, 0), mk(43, 0, 1), 1'b1, got, rdy, und);
    exp = expFrame(0, 16, 16, mk(43, 0, 0), mk(43, 0, 1), 1'b0);
    check(got === exp, "R10 recovery after underrun", got, exp);
    check(und === 1'b0, "R10 pulse cleared", {63'd0, und}, 64'd0);

    // R12: across every bit period driven above, serOut moved only after launch edges
    check(tErr == 0, "R12 output timing errors", 64'(tErr), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule